// File: doc/BRIEF.md
# Non-Revertive Reference Auto-Switch Controller

This block drives the select line of a two-input reference-clock mux. A loss-of-lock flag from the downstream PLL tells it when the active reference has failed. In manual mode the select simply tracks a software or strap select input.

In automatic mode the block first arms, which needs the lock flag to be low. Once armed, it flips to the other reference the first time the lock flag rises. It makes that flip only once and never returns on its own. After the flip it ignores the select input. A new arming needs automatic mode to be dropped and then raised again while lock is held.

All inputs are synchronous to the system clock. Every output is registered.

Top module: `ref_autoswitch`

## Requirements
- R1: While `auto_i` is 0, `sel_o` takes the value of `ref_sel_i` sampled at the previous clock edge (1 = reference 1, 0 = reference 0).
- R2: `armed_o` rises only after an edge at which `auto_i` was 1 and `lol_i` was 0.
- R3: While armed, an edge at which `lol_i` is 1 (a rise relative to the registered previous value) inverts `sel_o` at that edge and clears `armed_o`.
- R4: After an automatic switch, no further switch occurs while `auto_i` stays 1, whatever `lol_i` does, and `armed_o` stays 0.
- R5: After an automatic switch, `ref_sel_i` has no effect on `sel_o` until `auto_i` is sampled 0.
- R6: Arming again needs `auto_i` sampled 0 and then sampled 1 with `lol_i` 0. The 0 sample returns `sel_o` to `ref_sel_i`.
- R7: `ref_ack_o` equals `sel_o` on every cycle.
- R8: If `auto_i` rises while `lol_i` is 1, the block waits unarmed and makes no switch. It arms at the first edge where `lol_i` is 0.
- R9: After reset, `sel_o` is 0 and `armed_o` is 0.
- R10: When the new reference cannot be locked and `lol_i` stays 1 after a switch, `sel_o` keeps the switched value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_i | input | 1 | 1 = automatic mode, 0 = manual mode |
| ref_sel_i | input | 1 | Manual or initial reference choice |
| lol_i | input | 1 | Loss-of-lock flag, 1 = unlocked |
| sel_o | output | 1 | Mux select, 1 = reference 1 |
| ref_ack_o | output | 1 | Active reference indication |
| armed_o | output | 1 | 1 while automatic switching is armed |

## Verification
Some behaviours are checked on every cycle. These are:
- manual tracking of the select input;
- the arming precondition;
- the flip on a lock loss while armed;
- that the selection stays frozen and unarmed after a switch while automatic mode stays on.

Other behaviours only show up across the bench's sequences. These are:
- the pending wait when automatic mode rises during loss of lock;
- the full re-arm cycle with a second switch;
- holding the switched reference while lock never returns.

The bench compares the block against a behavioural model on every clock.

// File: rtl/ref_autoswitch_pkg.sv
package ref_autoswitch_pkg;
  typedef enum logic [1:0] {
    ST_MANUAL   = 2'd0,
    ST_ARM_WAIT = 2'd1,
    ST_ARMED    = 2'd2,
    ST_SWITCHED = 2'd3
  } sw_state_e;
endpackage

// File: rtl/ref_autoswitch_edge.sv
module ref_autoswitch_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lol_i,
  output logic lol_rise_o
);
  logic lol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lol_q <= 1'b1;
    else         lol_q <= lol_i;
  end

  assign lol_rise_o = lol_i & ~lol_q;
endmodule

// File: rtl/ref_autoswitch_fsm.sv
module ref_autoswitch_fsm
  import ref_autoswitch_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      auto_i,
  input  logic      lol_i,
  input  logic      lol_rise_i,
  output logic      flip_o,
  output logic      hold_o,
  output logic      armed_o
);
  sw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    flip_o  = 1'b0;
    unique case (state_q)
      ST_MANUAL:   if (auto_i) state_d = lol_i ? ST_ARM_WAIT : ST_ARMED;
      ST_ARM_WAIT: if (!auto_i) state_d = ST_MANUAL;
                   else if (!lol_i) state_d = ST_ARMED;
      ST_ARMED:    if (!auto_i) state_d = ST_MANUAL;
                   else if (lol_rise_i) begin
                     state_d = ST_SWITCHED;
                     flip_o  = 1'b1;
                   end
      ST_SWITCHED: if (!auto_i) state_d = ST_MANUAL;
      default:     state_d = ST_MANUAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_MANUAL;
    else         state_q <= state_d;
  end

  // selection frozen once switched and still in automatic mode
  assign hold_o  = (state_q == ST_SWITCHED) & auto_i;
  assign armed_o = (state_q == ST_ARMED);
endmodule

// File: rtl/ref_autoswitch_sel.sv
module ref_autoswitch_sel #(
  parameter logic RESET_SEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_sel_i,
  input  logic flip_i,
  input  logic hold_i,
  output logic sel_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= RESET_SEL;
    else if (flip_i) sel_q <= ~sel_q;
    else if (!hold_i) sel_q <= ref_sel_i;
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/ref_autoswitch.sv
module ref_autoswitch #(
  parameter logic RESET_SEL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic auto_i,
  input  logic ref_sel_i,
  input  logic lol_i,
  output logic sel_o,
  output logic ref_ack_o,
  output logic armed_o
);
  logic lol_rise, flip, hold, armed_d, armed_q;

  ref_autoswitch_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lol_i(lol_i), .lol_rise_o(lol_rise)
  );

  ref_autoswitch_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .auto_i(auto_i), .lol_i(lol_i),
    .lol_rise_i(lol_rise), .flip_o(flip), .hold_o(hold), .armed_o(armed_d)
  );

  ref_autoswitch_sel #(.RESET_SEL(RESET_SEL)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_sel_i(ref_sel_i),
    .flip_i(flip), .hold_i(hold), .sel_o(sel_o)
  );

  assign armed_q   = armed_d;
  assign armed_o   = armed_q;
  assign ref_ack_o = sel_o;
endmodule

// File: rtl/ref_autoswitch_chk.sv
module ref_autoswitch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic auto_i,
  input logic ref_sel_i,
  input logic lol_i,
  input logic sel_o,
  input logic ref_ack_o,
  input logic armed_o
);
  logic switched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          switched_q <= 1'b0;
    else if (!auto_i)                     switched_q <= 1'b0;
    else if (armed_o && lol_i)            switched_q <= 1'b1;
  end

  AST_MANUAL_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |=> sel_o == $past(ref_sel_i)); // R1
  AST_ARM_PRECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> $past(auto_i) && !$past(lol_i)); // R2
  AST_SWITCH_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o && auto_i && lol_i |=> sel_o != $past(sel_o) && !armed_o); // R3
  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switched_q |-> !armed_o); // R4
  AST_HOLD_AFTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switched_q && auto_i |=> $stable(sel_o)); // R5
  AST_ACK_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack_o == sel_o); // R7
endmodule

bind ref_autoswitch ref_autoswitch_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .auto_i(auto_i), .ref_sel_i(ref_sel_i),
  .lol_i(lol_i), .sel_o(sel_o), .ref_ack_o(ref_ack_o), .armed_o(armed_o)
);

// File: tb/ref_autoswitch_test.sv
module ref_autoswitch_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic auto_s = 1'b0, ref_sel_s = 1'b0, lol_s = 1'b0;
  logic sel, ack, armed;
  int checks = 0, errors = 0;
  string cur_req = "R9";
  bit done = 1'b0;

  // model state
  int m_sel = 0, m_armed = 0, m_used = 0, m_lol_prev = 1;

  always #10 clk = ~clk;

  ref_autoswitch uut (
    .clk_i(clk), .rst_ni(rst_n), .auto_i(auto_s), .ref_sel_i(ref_sel_s),
    .lol_i(lol_s), .sel_o(sel), .ref_ack_o(ack), .armed_o(armed)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_armed = 0; m_used = 0; m_lol_prev = 1;
    end else begin
      if (!auto_s) begin
        m_sel = ref_sel_s; m_armed = 0; m_used = 0;
      end else if (m_used != 0) begin
        // frozen
      end else if (m_armed != 0 && lol_s && m_lol_prev == 0) begin
        m_sel = 1 - m_sel; m_armed = 0; m_used = 1;
      end else begin
        m_sel = ref_sel_s;
        if (!lol_s) m_armed = 1;
      end
      m_lol_prev = lol_s;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // set inputs at a negedge, then compare at the next negedge
  task automatic cyc(logic a, logic r, logic l);
    auto_s = a; ref_sel_s = r; lol_s = l;
    @(negedge clk);
    chk(cur_req, "model sel", sel, m_sel);
    chk(cur_req, "model armed", armed, m_armed);
    chk("R7", "ack", ack, sel);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R9", "reset sel", sel, 0);
    chk("R9", "reset armed", armed, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 manual tracking
    cur_req = "R1";
    cyc(0, 1, 0); chk("R1", "sel follows 1", sel, 1);
    cyc(0, 0, 1); chk("R1", "sel follows 0", sel, 0);
    cyc(0, 1, 1); chk("R1", "sel follows 1 lol high", sel, 1);
    // R8 auto rises with lol high: pending
    cur_req = "R8";
    cyc(0, 0, 1);
    cyc(1, 0, 1); chk("R8", "pending not armed", armed, 0);
    cyc(1, 0, 1); chk("R8", "no switch while pending", sel, 0);
    cur_req = "R2";
    cyc(1, 0, 0); chk("R2", "armed after lol low", armed, 1);
    cyc(1, 0, 0); chk("R2", "still armed", armed, 1);
    // R3 switch
    cur_req = "R3";
    cyc(1, 0, 1); chk("R3", "flipped sel", sel, 1); chk("R3", "disarmed", armed, 0);
    chk("R7", "ack after flip", ack, 1);
    // R10 lol stays high
    cur_req = "R10";
    for (int i = 0; i < 4; i++) cyc(1, 0, 1);
    chk("R10", "sel held", sel, 1);
    // R4 further lol pulses
    cur_req = "R4";
    for (int i = 0; i < 3; i++) begin cyc(1, 0, 0); cyc(1, 0, 1); end
    chk("R4", "no second switch", sel, 1); chk("R4", "not rearmed", armed, 0);
    // R5 ref_sel ignored
    cur_req = "R5";
    cyc(1, 1, 0); cyc(1, 0, 0); chk("R5", "ref_sel ignored", sel, 1);
    // R6 rearm
    cur_req = "R6";
    cyc(1, 1, 0); chk("R6", "auto high alone no rearm", armed, 0);
    cyc(0, 1, 0); chk("R6", "manual reload", sel, 1);
    cyc(1, 1, 0); chk("R6", "rearmed", armed, 1);
    cyc(1, 1, 1); chk("R6", "second switch", sel, 0);
    cyc(1, 1, 0);
    cyc(0, 0, 0); chk("R6", "manual again", sel, 0);
    // lol already high at moment of arming path via pending, rising from pending ok
    cur_req = "R8";
    cyc(1, 1, 1); cyc(1, 1, 1); chk("R8", "no switch from level", sel, 1);
    cyc(1, 1, 0); chk("R8", "armed later", armed, 1);
    cyc(0, 0, 0); chk("R1", "drop auto disarms", armed, 0);
    @(negedge clk);
    finish_run();
  end
endmodule